// File: doc/BRIEF.md
# Binary64 Special-Operand Resolver for Add, Multiply and Fused Multiply-Add

This block sits beside the arithmetic core of a double-precision floating-point pipe. It looks at an operation code and up to three binary64 operands. It decides whether the operation is one whose outcome is fixed by the operand classes alone: a NaN is present, infinity meets zero in a product, or two infinities of opposite sign are summed. When that is the case, it supplies the final result and the invalid-operation flag, and the rounding datapath is not needed. When it is not the case, it reports that it has nothing to contribute, and the arithmetic core owns the result.

Operand `opnd_a` is the addend of a fused multiply-add, and `opnd_b` and `opnd_c` are its multiplicands, so the operation is a + b*c. For add, subtract (a - b) and multiply (a*b), only `opnd_a` and `opnd_b` are used. The whole unit is combinational.

Operations enter on a valid/ready stream and leave on another one, with no storage in between. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready` in the same cycle. Back-pressure from downstream therefore stalls the producer directly. An item is transferred in a cycle where both valid and ready are high. The producer must hold its inputs stable while it waits for ready.

Top module: `fmasr_top`

## Requirements
- R1: If exactly one of the operands in use is a NaN and that NaN is quiet (mantissa bit 51 set), and no infinity-times-zero occurs, the result is that NaN unchanged, `spec_valid` is 1 and `spec_invalid` is 0.
- R2: A signalling NaN (all-ones exponent, mantissa bit 51 clear, mantissa non-zero) that is selected as the result is returned with bit 51 set and every other bit kept, and `spec_invalid` is 1.
- R3: For add, subtract and multiply with both operands NaN, the NaN of `opnd_a` is returned, quieted.
- R4: For multiply-add with two or more NaN operands, the NaN returned is the first NaN found in this order: `opnd_a`, then `opnd_c`, then `opnd_b`. It is returned quieted.
- R5: `spec_invalid` is 1 whenever any operand in use is a signalling NaN, even when the returned NaN comes from a different operand that is quiet.
- R6: Infinity times zero gives the default NaN 0x7FF8000000000000 with `spec_invalid` = 1. This holds for multiply (a*b), and for multiply-add (b*c) when the addend is not a NaN.
- R7: Multiply-add with infinity times zero in b*c and a NaN addend returns the addend quieted, and `spec_invalid` is 1 even when the addend was quiet.
- R8: A sum of opposite-signed infinities gives the default NaN with `spec_invalid` = 1 when no NaN is present. The cases are: add with infinite a and b of different sign; subtract with infinite a and b of the same sign; multiply-add with infinite a and an infinite product whose sign (sign b XOR sign c) differs from a.
- R9: When none of the R1–R8 conditions hold (for example finite plus infinity, or finite times finite), `spec_valid` is 0, `spec_result` is 0 and `spec_invalid` is 0.
- R10: For op codes add (0), subtract (1) and multiply (2), `opnd_c` has no effect on any output. Op code 3 is multiply-add.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. The result outputs depend only on `op` and the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | An operation is offered on the inputs |
| in_ready | output | 1 | Consumer accepts; equals out_ready |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 multiply-add |
| opnd_a | input | 64 | First operand / multiply-add addend |
| opnd_b | input | 64 | Second operand / first multiplicand |
| opnd_c | input | 64 | Second multiplicand (multiply-add only) |
| out_valid | output | 1 | Result is offered; equals in_valid |
| out_ready | input | 1 | Downstream accepts the result |
| spec_valid | output | 1 | The result below is final and bypasses the core |
| spec_result | output | 64 | Special-case result |
| spec_invalid | output | 1 | Invalid-operation exception |

## Verification
The unit holds no state, so a wrong internal decision shows up at the ports in the same cycle as the operands that provoke it. The only evidence is a wrong result word, a missing or spurious invalid flag, or a wrong `spec_valid`. A misordered priority chain shows up only when two or three NaNs with distinct payloads meet. A missing quieting step shows up only when a signalling NaN is selected. The bench therefore sweeps every combination of ten operand classes, each operand slot carrying its own payload, across all four op codes, so that each such error has a combination that exposes it.

// File: rtl/fmasr_pkg.sv
package fmasr_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_FMA = 2'd3
  } fmasr_op_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_inf;
    logic is_zero;
  } fp_class_t;

endpackage

// File: rtl/fmasr_classify.sv
module fmasr_classify #(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output fmasr_pkg::fp_class_t cls
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             exp_max, exp_min, man_zero;

  assign expo     = val[W-2:MAN_W];
  assign man      = val[MAN_W-1:0];
  assign exp_max  = &expo;
  assign exp_min  = ~|expo;
  assign man_zero = ~|man;

  always_comb begin
    cls.sign    = val[W-1];
    cls.is_nan  = exp_max & ~man_zero;
    cls.is_snan = exp_max & ~man_zero & ~man[MAN_W-1];
    cls.is_inf  = exp_max & man_zero;
    cls.is_zero = exp_min & man_zero;
  end
endmodule

// File: rtl/fmasr_nan_pick.sv
module fmasr_nan_pick #(
  parameter int unsigned W    = 64,
  parameter int unsigned QBIT = 51,
  parameter int unsigned N    = 3
) (
  input  logic [N-1:0][W-1:0] cand,
  input  logic [N-1:0]        hit,
  output logic [W-1:0]        pick
);
  // slot 0 wins over slot 1 over slot 2 ...
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) pick = cand[i];
    end
    pick[QBIT] = 1'b1;
  end
endmodule

// File: rtl/fmasr_hazard.sv
module fmasr_hazard (
  input  fmasr_pkg::fmasr_op_e  op,
  input  fmasr_pkg::fp_class_t  ca,
  input  fmasr_pkg::fp_class_t  cb,
  input  fmasr_pkg::fp_class_t  cc,
  output logic                  inf_x_zero,
  output logic                  inf_cancel
);
  import fmasr_pkg::*;

  fp_class_t px, py;
  logic      is_fma, prod_inf, prod_sign;

  assign is_fma = (op == OP_FMA);
  assign px     = is_fma ? cb : ca;
  assign py     = is_fma ? cc : cb;

  always_comb begin
    inf_x_zero = ((op == OP_MUL) || is_fma) &&
                 ((px.is_inf && py.is_zero) || (px.is_zero && py.is_inf));
    prod_inf   = (cb.is_inf || cc.is_inf) && !inf_x_zero;
    prod_sign  = cb.sign ^ cc.sign;
    unique case (op)
      OP_ADD:  inf_cancel = ca.is_inf && cb.is_inf && (ca.sign != cb.sign);
      OP_SUB:  inf_cancel = ca.is_inf && cb.is_inf && (ca.sign == cb.sign);
      OP_FMA:  inf_cancel = ca.is_inf && prod_inf && (ca.sign != prod_sign);
      default: inf_cancel = 1'b0;
    endcase
  end
endmodule

// File: rtl/fmasr_top.sv
module fmasr_top #(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned MAN_W = 52
) (
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             op,
  input  logic [EXP_W+MAN_W:0]   opnd_a,
  input  logic [EXP_W+MAN_W:0]   opnd_b,
  input  logic [EXP_W+MAN_W:0]   opnd_c,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   spec_valid,
  output logic [EXP_W+MAN_W:0]   spec_result,
  output logic                   spec_invalid
);
  import fmasr_pkg::*;

  localparam int unsigned W    = 1 + EXP_W + MAN_W;
  localparam int unsigned QBIT = MAN_W - 1;
  localparam int unsigned NOPS = 3;
  localparam logic [W-1:0] DEFAULT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  fmasr_op_e                opc;
  logic [NOPS-1:0][W-1:0]   opnds;
  fp_class_t [NOPS-1:0]     cls;
  logic [NOPS-1:0]          used;
  logic [NOPS-1:0][W-1:0]   cand;
  logic [NOPS-1:0]          hit;
  logic [W-1:0]             nan_q;
  logic                     any_nan, any_snan, inf_x_zero, inf_cancel;

  assign opc       = fmasr_op_e'(op);
  assign opnds     = {opnd_c, opnd_b, opnd_a};
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fmasr_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val (opnds[g]),
      .cls (cls[g])
    );
  end

  assign used = (opc == OP_FMA) ? 3'b111 : 3'b011;

  // priority order: multiply-add is a, c, b; others a, b
  always_comb begin
    if (opc == OP_FMA) begin
      cand = {opnd_b, opnd_c, opnd_a};
      hit  = {cls[1].is_nan, cls[2].is_nan, cls[0].is_nan};
    end else begin
      cand = {opnd_c, opnd_b, opnd_a};
      hit  = {1'b0, cls[1].is_nan, cls[0].is_nan};
    end
  end

  always_comb begin
    any_snan = 1'b0;
    for (int i = 0; i < NOPS; i++) any_snan |= used[i] & cls[i].is_snan;
  end

  assign any_nan = |hit;

  fmasr_nan_pick #(.W(W), .QBIT(QBIT), .N(NOPS)) u_pick (
    .cand (cand),
    .hit  (hit),
    .pick (nan_q)
  );

  fmasr_hazard u_haz (
    .op         (opc),
    .ca         (cls[0]),
    .cb         (cls[1]),
    .cc         (cls[2]),
    .inf_x_zero (inf_x_zero),
    .inf_cancel (inf_cancel)
  );

  always_comb begin
    if (any_nan) begin
      spec_valid   = 1'b1;
      spec_result  = nan_q;
      spec_invalid = any_snan | inf_x_zero;
    end else if (inf_x_zero || inf_cancel) begin
      spec_valid   = 1'b1;
      spec_result  = DEFAULT_NAN;
      spec_invalid = 1'b1;
    end else begin
      spec_valid   = 1'b0;
      spec_result  = '0;
      spec_invalid = 1'b0;
    end
  end
endmodule

// File: rtl/fmasr_checker.sv
module fmasr_checker #(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned MAN_W = 52
) (
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [1:0]           op,
  input logic [EXP_W+MAN_W:0] opnd_a,
  input logic [EXP_W+MAN_W:0] opnd_b,
  input logic [EXP_W+MAN_W:0] opnd_c,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 spec_valid,
  input logic [EXP_W+MAN_W:0] spec_result,
  input logic                 spec_invalid
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;

  function automatic logic sig_nan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]) && !x[MAN_W-1];
  endfunction

  logic snan_seen;
  assign snan_seen = sig_nan(opnd_a) || sig_nan(opnd_b) || (op == 2'd3 && sig_nan(opnd_c));

  always_comb begin
    // R11
    stream_pass_chk: assert (out_valid == in_valid && in_ready == out_ready);
    // R9
    idle_zero_chk: assert (spec_valid || (spec_result == '0 && !spec_invalid));
    // R2
    quiet_out_chk: assert (!spec_valid ||
                           ((&spec_result[W-2:MAN_W]) && spec_result[MAN_W-1]));
    // R5
    snan_flag_chk: assert (!snan_seen || (spec_valid && spec_invalid));
  end
endmodule

bind fmasr_top fmasr_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fmasr_chk (
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .op           (op),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .opnd_c       (opnd_c),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .spec_valid   (spec_valid),
  .spec_result  (spec_result),
  .spec_invalid (spec_invalid)
);

// File: tb/test_fmasr_top.sv
module test_fmasr_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] QBIT = 64'h0008_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [1:0] op;
  logic [63:0] opnd_a, opnd_b, opnd_c, spec_result;
  logic spec_valid, spec_invalid;
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmasr_top i_fmasr_top (
    .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .out_valid(out_valid), .out_ready(out_ready),
    .spec_valid(spec_valid), .spec_result(spec_result), .spec_invalid(spec_invalid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic f_nan(input logic [63:0] x);  return (&x[62:52]) && (|x[51:0]); endfunction
  function automatic logic f_snan(input logic [63:0] x); return f_nan(x) && !x[51]; endfunction
  function automatic logic f_inf(input logic [63:0] x);  return (&x[62:52]) && !(|x[51:0]); endfunction
  function automatic logic f_zero(input logic [63:0] x); return x[62:0] == '0; endfunction

  // operand value i in slot s; NaN payloads differ per slot
  function automatic logic [63:0] val(input int i, input int s);
    case (i)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000;
      3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h7FF0_0000_0000_0000;
      5: return 64'hFFF0_0000_0000_0000;
      6: return 64'h7FEF_FFFF_FFFF_FFFF;
      7: return 64'h7FF8_0000_0000_0000 | 64'(s + 1);
      8: return 64'h7FF0_0000_0000_0000 | 64'(s + 1);
      default: return 64'hFFF0_0000_0000_0100 | 64'(s + 1);
    endcase
  endfunction

  task automatic expect_of(input logic [1:0] o, input logic [63:0] a, b, c,
                           output logic ev, output logic [63:0] er, output logic ei,
                           output string tag);
    logic [63:0] ord [3];
    int n, nn;
    logic i0, sn, found;
    if (o == 2'd3) begin ord[0] = a; ord[1] = c; ord[2] = b; n = 3; end
    else begin ord[0] = a; ord[1] = b; ord[2] = 0; n = 2; end
    i0 = (o == 2'd2) ? ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) :
         (o == 2'd3) ? ((f_inf(b) && f_zero(c)) || (f_zero(b) && f_inf(c))) : 1'b0;
    sn = 0; nn = 0; found = 0; er = 0;
    for (int k = 0; k < n; k++) begin
      if (f_snan(ord[k])) sn = 1;
      if (f_nan(ord[k])) begin
        nn++;
        if (!found) begin er = ord[k] | QBIT; found = 1; end
      end
    end
    if (found) begin
      ev = 1; ei = sn | i0;
      if (nn > 1) tag = (o == 2'd3) ? "R4" : "R3";
      else if (i0) tag = "R7";
      else if (sn) tag = "R2";
      else tag = "R1";
    end else if (i0) begin
      ev = 1; er = DNAN; ei = 1; tag = "R6";
    end else if ((o == 2'd0 && f_inf(a) && f_inf(b) && a[63] != b[63]) ||
                 (o == 2'd1 && f_inf(a) && f_inf(b) && a[63] == b[63]) ||
                 (o == 2'd3 && f_inf(a) && (f_inf(b) || f_inf(c)) && a[63] != (b[63] ^ c[63]))) begin
      ev = 1; er = DNAN; ei = 1; tag = "R8";
    end else begin
      ev = 0; er = 0; ei = 0; tag = "R9";
    end
  endtask

  task automatic check(input string tag, input logic ev, input logic [63:0] er, input logic ei);
    checks++;
    if (spec_valid !== ev || spec_result !== er || spec_invalid !== ei) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h c=%h : got v=%b r=%h i=%b exp v=%b r=%h i=%b",
               tag, op, opnd_a, opnd_b, opnd_c, spec_valid, spec_result, spec_invalid, ev, er, ei);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [63:0] a, b, c);
    @(posedge clk);
    op = o; opnd_a = a; opnd_b = b; opnd_c = c;
    @(negedge clk);
  endtask

  task automatic run_one(input logic [1:0] o, input logic [63:0] a, b, c, input string force_tag);
    logic ev, ei; logic [63:0] er; string t;
    apply(o, a, b, c);
    expect_of(o, a, b, c, ev, er, ei, t);
    check((force_tag != "") ? force_tag : t, ev, er, ei);
  endtask

  task automatic check_stream(input logic iv, input logic ordy);
    @(posedge clk);
    in_valid = iv; out_ready = ordy;
    @(negedge clk);
    checks++;
    if (out_valid !== iv || in_ready !== ordy) begin
      failures++;
      $display("FAIL R11 got out_valid=%b in_ready=%b exp %b %b", out_valid, in_ready, iv, ordy);
    end
  endtask

  initial begin
    in_valid = 0; out_ready = 0; op = 0; opnd_a = 0; opnd_b = 0; opnd_c = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: nothing offered, nothing special (R11, R9)
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
      failures++; $display("FAIL R11 idle got %b %b exp 0 0", out_valid, in_ready);
    end
    check("R9", 1'b0, 64'h0, 1'b0);

    for (int v = 0; v < 2; v++)
      for (int r = 0; r < 2; r++) check_stream(v[0], r[0]);
    in_valid = 1; out_ready = 1;

    // directed corner cases
    run_one(2'd3, val(7,0), val(7,1), val(7,2), "R4");   // all quiet -> a
    run_one(2'd3, val(2,0), val(7,1), val(7,2), "R4");   // b,c -> c
    run_one(2'd3, val(7,0), val(8,1), val(2,2), "R5");   // a quiet returned, b signalling
    run_one(2'd3, val(7,0), val(4,1), val(0,2), "R7");   // quiet addend, inf*0
    run_one(2'd3, val(8,0), val(4,1), val(1,2), "R7");
    run_one(2'd3, val(2,0), val(5,1), val(0,2), "R6");
    run_one(2'd2, val(4,0), val(1,1), val(2,2), "R6");
    run_one(2'd0, val(4,0), val(5,1), val(2,2), "R8");
    run_one(2'd1, val(5,0), val(5,1), val(2,2), "R8");
    run_one(2'd0, val(2,0), val(4,1), val(2,2), "R9");   // finite + inf stays with core
    run_one(2'd0, val(8,0), val(8,1), val(2,2), "R3");
    run_one(2'd1, val(2,0), val(8,1), val(2,2), "R2");
    run_one(2'd0, val(2,0), val(7,1), val(2,2), "R1");
    // R10: c is a signalling NaN but unused
    for (int o = 0; o < 3; o++) run_one(2'(o), val(2,0), val(3,1), val(8,2), "R10");
    run_one(2'd2, val(6,0), val(6,1), val(9,2), "R10");

    // sweep of all class combinations
    for (int o = 0; o < 4; o++)
      for (int ia = 0; ia < 10; ia++)
        for (int ib = 0; ib < 10; ib++)
          for (int ic = 0; ic < 10; ic++)
            run_one(2'(o), val(ia,0), val(ib,1), val(ic,2), "");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule